// File: doc/BRIEF.md
# Dual Frame Clock Generator

This block produces the left/right frame clocks for an audio serial port when the port is master. There are two paths, capture and playback. Each has its own frame clock and its own 11-bit period. Both periods are counted in bit-clock edges, which arrive as a single-cycle enable stream shared by the two paths. The frame rates are not derived from the converter rates: each is programmed on its own. When the two paths run at different rates, the bit-clock stream must be fast enough for the faster of them. That is a system rule; the block does not check it.

A frame starts with its clock high. The clock falls after half the programmed count of edges, and for an odd count the high half is one edge longer. A new period takes effect only at the next frame boundary. A period below two is rejected: the affected clock stays low and a warning flag is raised. In slave mode the block is idle. Both outputs are low and every counter is held cleared.

The block has no data stream, so it has no valid/ready handshake. Every pin is a plain control or status level, sampled on each clock cycle. The block never applies back-pressure.

Top module: `lrc_dual_gen`

## Requirements
- R1: While rst_n is low, cap_lrc, play_lrc and cfg_warn are all 0.
- R2: When master is 0, both frame clocks and cfg_warn are 0 from the next cycle onward. Frame counting restarts from the beginning when master returns to 1.
- R3: In the cycle after master goes from 0 to 1 with a valid rate, that path's frame clock is 1. This is the start of a frame.
- R4: With a programmed rate N, a frame lasts N bit-clock enables. The clock is 1 for the first (N+1)/2 of them (rounded down) and 0 for the remaining N/2.
- R5: In master mode with a valid rate, a frame clock changes only in the cycle after bclk_en was 1.
- R6: The capture and playback paths count independently from the same bclk_en stream, each using its own rate.
- R7: A rate value of 0 or 1 keeps that path's clock at 0 and sets cfg_warn to 1. In the cycle after a value of 2 or more is applied, cfg_warn returns to 0 and the clock starts a frame at 1.
- R8: A rate written in the middle of a frame does not alter that frame. It governs the frame that follows.
- R9: The full 11-bit range is usable. A rate of 2047 gives 1024 enables high and 1023 enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master | input | 1 | 1 = generate frame clocks, 0 = slave (idle) |
| bclk_en | input | 1 | One-cycle pulse per bit-clock edge |
| cap_rate | input | 11 | Capture frame period in bit-clock enables |
| play_rate | input | 11 | Playback frame period in bit-clock enables |
| cap_lrc | output | 1 | Capture frame clock |
| play_lrc | output | 1 | Playback frame clock |
| cfg_warn | output | 1 | 1 while either path holds a rate below 2 |

## Verification
The bench builds the block with its default 11-bit rate width and a minimum valid rate of 2. This covers the smallest periods (2 and 3) as well as the largest, 2047, and the 2047 run checks the 1024/1023 split. A table walk pairs odd and even periods across the two paths. It also changes a rate in the middle of a frame, so boundary loading and path independence are checked against a model kept in the bench. Directed cases cover reset, slave hold and restart, and recovery from an invalid rate.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  localparam int NUM_PATHS = 2;
  typedef enum int {PATH_CAP = 0, PATH_PLAY = 1} path_e;
endpackage

// File: rtl/lrc_rate_dec.sv
module lrc_rate_dec #(
  parameter int RATE_W   = 11,
  parameter int MIN_RATE = 2
) (
  input  logic [RATE_W-1:0] rate,
  output logic              ok,
  output logic [RATE_W-1:0] hi_len
);
  localparam int EXT_W = RATE_W + 1;
  logic [EXT_W-1:0] sum;

  always_comb begin
    ok     = (int'(rate) >= MIN_RATE);
    sum    = {1'b0, rate} + EXT_W'(1);
    hi_len = sum[EXT_W-1:1];
  end
endmodule

// File: rtl/lrc_chan.sv
module lrc_chan #(
  parameter int RATE_W   = 11,
  parameter int MIN_RATE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              bclk_en,
  input  logic [RATE_W-1:0] rate_in,
  output logic              lrc,
  output logic              warn
);
  logic [RATE_W-1:0] act_q, cnt_q, cnt_nx, act_hi, in_hi;
  logic              lrc_q, live_q, act_ok, in_ok;

  lrc_rate_dec #(.RATE_W(RATE_W), .MIN_RATE(MIN_RATE)) u_act_dec (
    .rate(act_q), .ok(act_ok), .hi_len(act_hi));
  lrc_rate_dec #(.RATE_W(RATE_W), .MIN_RATE(MIN_RATE)) u_in_dec (
    .rate(rate_in), .ok(in_ok), .hi_len(in_hi));

  assign cnt_nx = cnt_q + RATE_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0; cnt_q <= '0; lrc_q <= 1'b0; live_q <= 1'b0;
    end else if (!master) begin
      act_q <= '0; cnt_q <= '0; lrc_q <= 1'b0; live_q <= 1'b0;
    end else if (!live_q || !act_ok) begin
      live_q <= 1'b1;
      act_q  <= rate_in;
      cnt_q  <= '0;
      lrc_q  <= in_ok;
    end else if (bclk_en) begin
      if (cnt_nx == act_q) begin
        cnt_q <= '0;
        act_q <= rate_in;
        lrc_q <= in_ok;
      end else begin
        cnt_q <= cnt_nx;
        if (cnt_nx == act_hi) lrc_q <= 1'b0;
      end
    end
  end

  assign lrc  = lrc_q;
  assign warn = live_q && !act_ok;

  p_slave_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !master |=> (!lrc_q && !live_q && cnt_q == '0));
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && act_ok) |-> (cnt_q < act_q));
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (master && live_q && act_ok && !bclk_en) |=> $stable(lrc_q));
  p_invalid_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !act_ok) |-> !lrc_q);
  p_rate_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (master && live_q && act_ok && !(bclk_en && cnt_nx == act_q)) |=> $stable(act_q));
endmodule

// File: rtl/lrc_dual_gen.sv
module lrc_dual_gen #(
  parameter int RATE_W   = 11,
  parameter int MIN_RATE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              bclk_en,
  input  logic [RATE_W-1:0] cap_rate,
  input  logic [RATE_W-1:0] play_rate,
  output logic              cap_lrc,
  output logic              play_lrc,
  output logic              cfg_warn
);
  import lrc_pkg::*;

  logic [RATE_W-1:0] rate_v [NUM_PATHS];
  logic [NUM_PATHS-1:0] lrc_v, warn_v;

  assign rate_v[PATH_CAP]  = cap_rate;
  assign rate_v[PATH_PLAY] = play_rate;

  for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
    lrc_chan #(.RATE_W(RATE_W), .MIN_RATE(MIN_RATE)) u_chan (
      .clk(clk), .rst_n(rst_n), .master(master), .bclk_en(bclk_en),
      .rate_in(rate_v[g]), .lrc(lrc_v[g]), .warn(warn_v[g]));
  end

  assign cap_lrc  = lrc_v[PATH_CAP];
  assign play_lrc = lrc_v[PATH_PLAY];
  assign cfg_warn = |warn_v;

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!cap_lrc && !play_lrc && !cfg_warn));
  p_slave_nowarn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !master |=> !cfg_warn);
endmodule

// File: tb/tb_lrc_dual_gen.sv
module tb_lrc_dual_gen;
  logic clk = 1'b0, rst_n = 1'b0, master = 1'b0, bclk_en = 1'b0;
  logic [10:0] cap_rate = 11'd4, play_rate = 11'd4;
  logic cap_lrc, play_lrc, cfg_warn;
  int checks = 0, errors = 0;
  int mcur[2], mpos[2];

  always #5 clk = ~clk;

  lrc_dual_gen dut (.clk(clk), .rst_n(rst_n), .master(master), .bclk_en(bclk_en),
    .cap_rate(cap_rate), .play_rate(play_rate),
    .cap_lrc(cap_lrc), .play_lrc(play_lrc), .cfg_warn(cfg_warn));

  // columns: cap0, play0, cap1, play1, pulses before switching rates, total pulses
  localparam int NV = 5;
  localparam int TV[NV][6] = '{
    '{2, 3, 2, 3, 0, 12},
    '{3, 2, 5, 7, 4, 30},
    '{4, 6, 6, 3, 1, 26},
    '{5, 8, 5, 8, 0, 26},
    '{13, 4, 9, 4, 7, 40}};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lrc(int p);
    return (mpos[p] < (mcur[p] + 1) / 2) ? 1 : 0;
  endfunction

  task automatic cyc(logic en);
    @(negedge clk) bclk_en = en;
    @(posedge clk);
    @(negedge clk) bclk_en = 1'b0;
  endtask

  task automatic model_edge();
    for (int p = 0; p < 2; p++) begin
      mpos[p]++;
      if (mpos[p] == mcur[p]) begin
        mpos[p] = 0;
        mcur[p] = (p == 0) ? int'(cap_rate) : int'(play_rate);
      end
    end
  endtask

  task automatic enter_master();
    @(negedge clk) master = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mcur[0] = int'(cap_rate); mcur[1] = int'(play_rate);
    mpos[0] = 0; mpos[1] = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset holds outputs low even with master requested
    master = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 cap_lrc", cap_lrc, 0);
    check("R1 play_lrc", play_lrc, 0);
    check("R1 cfg_warn", cfg_warn, 0);
    master = 1'b0;
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk) master = 1'b0;
      cap_rate = 11'(TV[v][0]); play_rate = 11'(TV[v][1]);
      cyc(1'b1); cyc(1'b1);
      check("R2 slave cap_lrc", cap_lrc, 0);
      check("R2 slave play_lrc", play_lrc, 0);
      check("R2 slave cfg_warn", cfg_warn, 0);
      enter_master();
      check("R3 cap frame start", cap_lrc, 1);
      check("R3 play frame start", play_lrc, 1);
      for (int k = 0; k < TV[v][5]; k++) begin
        if (TV[v][4] != 0 && k == TV[v][4]) begin
          cap_rate = 11'(TV[v][2]); play_rate = 11'(TV[v][3]);
        end
        cyc(1'b1);
        model_edge();
        check("R4/R6/R8 cap_lrc", cap_lrc, exp_lrc(0));
        check("R4/R6/R8 play_lrc", play_lrc, exp_lrc(1));
        cyc(1'b0);
        check("R5 cap idle", cap_lrc, exp_lrc(0));
        check("R5 play idle", play_lrc, exp_lrc(1));
      end
      check("R7 no warn on valid", cfg_warn, 0);
    end

    // R7: invalid capture rate, playback unaffected
    @(negedge clk) master = 1'b0; cap_rate = 11'd1; play_rate = 11'd3;
    cyc(1'b0);
    enter_master();
    check("R7 warn set", cfg_warn, 1);
    check("R7 cap held low", cap_lrc, 0);
    for (int k = 0; k < 5; k++) begin
      cyc(1'b1);
      model_edge();
      check("R7 cap still low", cap_lrc, 0);
      check("R6 play runs", play_lrc, exp_lrc(1));
    end
    @(negedge clk) cap_rate = 11'd0;
    cyc(1'b1);
    check("R7 zero rate warns", cfg_warn, 1);
    @(negedge clk) cap_rate = 11'd4;
    @(posedge clk);
    @(negedge clk);
    check("R7 warn cleared", cfg_warn, 0);
    check("R7 frame starts high", cap_lrc, 1);

    // R2: slave mid-frame then restart from frame start
    cyc(1'b1);
    @(negedge clk) master = 1'b0;
    cyc(1'b1);
    check("R2 low in slave", cap_lrc, 0);
    enter_master();
    cyc(1'b1);
    check("R2 counter restarted", cap_lrc, 1);
    cyc(1'b1);
    check("R2 restarted fall at 2", cap_lrc, 0);

    // R9: maximum period
    @(negedge clk) master = 1'b0; cap_rate = 11'd2047; play_rate = 11'd2;
    cyc(1'b0);
    enter_master();
    for (int k = 0; k < 1023; k++) cyc(1'b1);
    check("R9 high through 1023", cap_lrc, 1);
    cyc(1'b1);
    check("R9 low at 1024", cap_lrc, 0);
    for (int k = 0; k < 1022; k++) cyc(1'b1);
    check("R9 low at 2046", cap_lrc, 0);
    cyc(1'b1);
    check("R9 new frame at 2047", cap_lrc, 1);

    // R1: reset asserted while running
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R1 async reset cap", cap_lrc, 0);
    check("R1 async reset play", play_lrc, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule